// File: doc/BRIEF.md
# Display Command Stream Executor

This block runs a queue of register-programming instructions for a display pipe. The instructions sit in a local command memory that software fills word by word through a load port. Each instruction is two 32-bit words. A start is requested by writing a tail byte address while the block is enabled and idle. Execution then begins at the instruction slot given by the head input. Instructions are decoded one after another until the current pointer reaches the tail, and busy stays high for the whole run.

Several kinds of instruction exist. Plain register writes carry per-byte enables. An indexed write sends a run of data words to one register offset. A wait can count microsecond ticks or vblank pulses. An interrupt instruction raises a status bit. The three scanline-window waits are not timed inside this block: it passes them to a separate wait unit through a one-cycle start pulse and waits for that unit's done pulse. A halt input, or dropping the enable, stops the run. After a stop the current head address stays visible at the ports. Errors are recorded in sticky status bits, and `irq` is the OR of all status bits.

Top module: `disp_cmd_exec`

## Requirements
- R1: An instruction occupies two words at an even word index. The low word is the operand. The high word carries the opcode in bits 31:24. `head_slot` counts 8-byte slots, so the first instruction is at byte address 8*head_slot.
- R2: Opcode 0x01 drives one register write. The address is high-word bits 19:0, the byte enables are high-word bits 23:20 and the data is the low word. `wr_valid` is high for exactly one cycle, in the cycle after the instruction is decoded.
- R3: Opcode 0x00 makes no write and no stall, and execution continues with the next instruction.
- R4: Opcode 0x09 takes a count N from its low word. It writes the N data words that follow it, in order, to offset bits 19:0 with all byte enables set. The next instruction is at the header index plus 2 plus N rounded up to even, which skips the pad word. When N is 0 there are no writes.
- R5: Opcode 0x02 stalls until as many `us_tick` pulses as its low word have arrived. The next instruction is decoded on the cycle after the last of these ticks. A count of 0 does not stall.
- R6: Opcode 0x04 stalls for as many `vblank` pulses as its low word. `us_tick` pulses do not shorten this wait.
- R7: Opcodes 0x03, 0x05 and 0x06 pulse `sl_start` for one cycle, presenting the opcode on `sl_op`, the low word on `sl_lo` and high-word bits 19:0 on `sl_hi`. Execution resumes only after `sl_done` is seen.
- R8: Opcode 0x07 sets the sticky `sts_prog`, and so does reaching the tail. A `clr_prog` pulse clears it, and a set in the same cycle wins. `irq` is the OR of the three status bits.
- R9: A `tail_wr` pulse starts a run when `enable` is high, the block is idle, `halt` is low and `tail_byte` bits 5:0 are zero. Busy then stays high until the current pointer equals tail_byte/4. A tail equal to the head completes at once with `sts_prog` set.
- R10: A `tail_wr` pulse with a tail that is not a multiple of 64 bytes, while enabled and idle, sets `sts_align_err` and does not start a run. A `clr_err` pulse clears the error bits.
- R11: A `tail_wr` pulse while busy is ignored. The run ends at the tail it was started with.
- R12: When `halt` is high, or `enable` is low, while busy, the block goes idle on the next edge. `cur_head` then holds the byte address of the instruction that was executing.
- R13: Any other opcode (for example 0x08, 0x0A, 0x0B to 0xFF) sets `sts_op_err` and stops the run. `cur_head` then points at the offending instruction, and nothing after it is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Command memory load strobe |
| ld_addr | input | AW | Command memory word index |
| ld_data | input | 32 | Word to load |
| enable | input | 1 | Engine enable |
| head_slot | input | AW-1 | First instruction, in 8-byte slots |
| tail_wr | input | 1 | Tail write / start request |
| tail_byte | input | AW+2 | Tail byte address |
| halt | input | 1 | Stop request |
| us_tick | input | 1 | Microsecond tick pulse |
| vblank | input | 1 | Vblank pulse |
| sl_done | input | 1 | Scanline wait unit finished |
| clr_prog | input | 1 | Write-1-to-clear for sts_prog |
| clr_err | input | 1 | Write-1-to-clear for error bits |
| busy | output | 1 | Run in progress |
| cur_head | output | AW+2 | Byte address of current instruction |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 20 | Register offset |
| wr_be | output | 4 | Byte enables |
| wr_data | output | 32 | Write data |
| sl_start | output | 1 | Scanline wait request pulse |
| sl_op | output | 8 | Scanline wait opcode |
| sl_lo | output | 32 | Scanline wait low operand |
| sl_hi | output | 20 | Scanline wait high operand bits |
| sts_prog | output | 1 | Program / completion status |
| sts_align_err | output | 1 | Misaligned tail status |
| sts_op_err | output | 1 | Unknown opcode status |
| irq | output | 1 | OR of status bits |

## Verification
A wrong current pointer shows up within a cycle or two as writes to the wrong offset, a skipped or duplicated indexed data word, or a run that never drops busy. The bench compares exact write counts, addresses and data, and the stopping address on `cur_head`, so these faults are caught. A faulty wait counter appears as a write released one tick or pulse early or late. This is caught because the bench records how many pulses it had issued when the first write appeared. Errors in the status or start logic appear as a wrong `busy` or status bit on the cycle right after the triggering pulse.

// File: rtl/disp_cmd_exec.sv
module disp_cmd_exec #(
  parameter int AW = 8,
  parameter int ALIGN_LOG2 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [31:0]     ld_data,
  input  logic            enable,
  input  logic [AW-2:0]   head_slot,
  input  logic            tail_wr,
  input  logic [AW+1:0]   tail_byte,
  input  logic            halt,
  input  logic            us_tick,
  input  logic            vblank,
  input  logic            sl_done,
  input  logic            clr_prog,
  input  logic            clr_err,
  output logic            busy,
  output logic [AW+1:0]   cur_head,
  output logic            wr_valid,
  output logic [19:0]     wr_addr,
  output logic [3:0]      wr_be,
  output logic [31:0]     wr_data,
  output logic            sl_start,
  output logic [7:0]      sl_op,
  output logic [31:0]     sl_lo,
  output logic [19:0]     sl_hi,
  output logic            sts_prog,
  output logic            sts_align_err,
  output logic            sts_op_err,
  output logic            irq
);
  localparam int WORDS = 1 << AW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_WR   = 8'h01;
  localparam logic [7:0] OP_WUS  = 8'h02;
  localparam logic [7:0] OP_WSL  = 8'h03;
  localparam logic [7:0] OP_WVB  = 8'h04;
  localparam logic [7:0] OP_WIN  = 8'h05;
  localparam logic [7:0] OP_WOUT = 8'h06;
  localparam logic [7:0] OP_IRQ  = 8'h07;
  localparam logic [7:0] OP_IDX  = 8'h09;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_IDX, S_WUS, S_WVB, S_WSL} st_t;

  st_t st;
  logic [31:0]   mem [WORDS];
  logic [AW-1:0] cur, tail_w, dptr;
  logic [31:0]   cnt;

  always_ff @(posedge clk)
    if (ld_we) mem[ld_addr] <= ld_data;

  wire [AW-1:0] cur_odd  = {cur[AW-1:1], 1'b1};
  wire [31:0]   ins_lo   = mem[cur];
  wire [31:0]   ins_hi   = mem[cur_odd];
  wire [7:0]    op       = ins_hi[31:24];
  wire [AW-1:0] nxt      = cur + TWO;
  wire [AW-1:0] dnext    = dptr + ONE;
  wire [AW-1:0] idx_end  = dnext[0] ? dnext + ONE : dnext;
  wire          idle     = (st == S_IDLE);
  wire          stop     = halt | ~enable;
  wire          aligned  = (tail_byte[ALIGN_LOG2-1:0] == '0);
  wire          start_ok = tail_wr & enable & idle & ~halt & aligned;
  wire          bad_tail = tail_wr & enable & idle & ~aligned;

  assign busy     = ~idle;
  assign cur_head = {cur, 2'b00};
  assign irq      = sts_prog | sts_align_err | sts_op_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cur           <= '0;
      tail_w        <= '0;
      dptr          <= '0;
      cnt           <= '0;
      wr_valid      <= 1'b0;
      wr_addr       <= '0;
      wr_be         <= '0;
      wr_data       <= '0;
      sl_start      <= 1'b0;
      sl_op         <= '0;
      sl_lo         <= '0;
      sl_hi         <= '0;
      sts_prog      <= 1'b0;
      sts_align_err <= 1'b0;
      sts_op_err    <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      sl_start <= 1'b0;
      if (clr_prog) sts_prog <= 1'b0;
      if (clr_err) begin
        sts_align_err <= 1'b0;
        sts_op_err    <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (start_ok) begin
            cur    <= {head_slot, 1'b0};
            tail_w <= tail_byte[AW+1:2];
            st     <= S_RUN;
          end
          if (bad_tail) sts_align_err <= 1'b1;
        end
        S_RUN: begin
          if (stop) st <= S_IDLE;
          else if (cur == tail_w) begin
            st       <= S_IDLE;
            sts_prog <= 1'b1;
          end else begin
            case (op)
              OP_NOP: cur <= nxt;
              OP_WR: begin
                wr_valid <= 1'b1;
                wr_addr  <= ins_hi[19:0];
                wr_be    <= ins_hi[23:20];
                wr_data  <= ins_lo;
                cur      <= nxt;
              end
              OP_WUS, OP_WVB: begin
                cnt <= ins_lo;
                if (ins_lo == '0) cur <= nxt;
                else st <= (op == OP_WUS) ? S_WUS : S_WVB;
              end
              OP_WSL, OP_WIN, OP_WOUT: begin
                sl_start <= 1'b1;
                sl_op    <= op;
                sl_lo    <= ins_lo;
                sl_hi    <= ins_hi[19:0];
                st       <= S_WSL;
              end
              OP_IRQ: begin
                sts_prog <= 1'b1;
                cur      <= nxt;
              end
              OP_IDX: begin
                cnt  <= ins_lo;
                dptr <= nxt;
                if (ins_lo == '0) cur <= nxt;
                else st <= S_IDX;
              end
              default: begin
                sts_op_err <= 1'b1;
                st         <= S_IDLE;
              end
            endcase
          end
        end
        S_IDX: begin
          if (stop) st <= S_IDLE;
          else begin
            wr_valid <= 1'b1;
            wr_addr  <= ins_hi[19:0];
            wr_be    <= 4'hF;
            wr_data  <= mem[dptr];
            dptr     <= dnext;
            cnt      <= cnt - 32'd1;
            if (cnt == 32'd1) begin
              cur <= idx_end;
              st  <= S_RUN;
            end
          end
        end
        S_WUS, S_WVB: begin
          if (stop) st <= S_IDLE;
          else if ((st == S_WUS) ? us_tick : vblank) begin
            cnt <= cnt - 32'd1;
            if (cnt == 32'd1) begin
              cur <= nxt;
              st  <= S_RUN;
            end
          end
        end
        S_WSL: begin
          if (stop) st <= S_IDLE;
          else if (sl_done) begin
            cur <= nxt;
            st  <= S_RUN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_wr && enable && !busy && !halt && tail_byte[ALIGN_LOG2-1:0] == '0) |=> busy);

  a_r10_misaligned_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_wr && enable && !busy && tail_byte[ALIGN_LOG2-1:0] != '0) |=> (!busy && sts_align_err));

  a_r11_tail_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tail_wr) |=> $stable(tail_w));

  a_r12_halt_stops_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt) |=> (!busy && $stable(cur_head)));

  a_r2_write_only_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(busy));

  a_r7_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sl_start |=> !sl_start);

  a_r13_op_err_idles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_op_err) |-> !busy);

  a_r8_prog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_prog && !clr_prog) |=> sts_prog);
endmodule

// File: tb/disp_cmd_exec_bench.sv
module disp_cmd_exec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic enable = 1'b1;
  logic [AW-2:0] head_slot = '0;
  logic tail_wr = 1'b0;
  logic [AW+1:0] tail_byte = '0;
  logic halt = 1'b0, us_tick = 1'b0, vblank = 1'b0, sl_done = 1'b0;
  logic clr_prog = 1'b0, clr_err = 1'b0;
  logic busy, wr_valid, sl_start, sts_prog, sts_align_err, sts_op_err, irq;
  logic [AW+1:0] cur_head;
  logic [19:0] wr_addr, sl_hi;
  logic [3:0] wr_be;
  logic [31:0] wr_data, sl_lo;
  logic [7:0] sl_op;

  disp_cmd_exec #(.AW(AW), .ALIGN_LOG2(6)) u_disp_cmd_exec (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .enable(enable), .head_slot(head_slot), .tail_wr(tail_wr), .tail_byte(tail_byte),
    .halt(halt), .us_tick(us_tick), .vblank(vblank), .sl_done(sl_done),
    .clr_prog(clr_prog), .clr_err(clr_err), .busy(busy), .cur_head(cur_head),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .sl_start(sl_start), .sl_op(sl_op), .sl_lo(sl_lo), .sl_hi(sl_hi),
    .sts_prog(sts_prog), .sts_align_err(sts_align_err), .sts_op_err(sts_op_err), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, wcount = 0, slcount = 0;
  int us_issued = 0, vb_issued = 0, us_at_wr = -1, vb_at_wr = -1;
  logic [19:0] log_addr [16];
  logic [3:0]  log_be   [16];
  logic [31:0] log_data [16];
  logic [7:0]  cap_op;
  logic [31:0] cap_lo;
  logic [19:0] cap_hi;
  bit finished = 0;

  always @(negedge clk) begin
    if (wr_valid) begin
      if (wcount < 16) begin
        log_addr[wcount] = wr_addr;
        log_be[wcount]   = wr_be;
        log_data[wcount] = wr_data;
      end
      if (wcount == 0) begin
        us_at_wr = us_issued;
        vb_at_wr = vb_issued;
      end
      wcount++;
    end
    if (sl_start) begin
      cap_op = sl_op; cap_lo = sl_lo; cap_hi = sl_hi;
      slcount++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int idx, logic [31:0] lo, logic [31:0] hi);
    ld_we = 1'b1;
    ld_addr = AW'(idx);   ld_data = lo; step();
    ld_addr = AW'(idx+1); ld_data = hi; step();
    ld_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 48; i += 2) put(i, 32'h0, 32'h0);
  endtask

  task automatic fresh();
    clr_prog = 1'b1; clr_err = 1'b1; step(); clr_prog = 1'b0; clr_err = 1'b0;
    clear_mem();
    wcount = 0; slcount = 0; us_issued = 0; vb_issued = 0; us_at_wr = -1; vb_at_wr = -1;
  endtask

  task automatic start(int slot, int tb);
    head_slot = (AW-1)'(slot); tail_byte = (AW+2)'(tb); tail_wr = 1'b1; step(); tail_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin step(); n++; end
  endtask

  task automatic pulse_vb();
    vblank = 1'b1; vb_issued++; step(); vblank = 1'b0;
  endtask

  localparam int NV = 5;
  localparam logic [31:0] T_LO   [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h0000FFFF, 32'hCAFEF00D, 32'h00000001};
  localparam logic [31:0] T_HI   [NV] = '{32'h01F00104, 32'h013ABCDE, 32'h018FFFFF, 32'h00000000, 32'h01500000};
  localparam int          T_N    [NV] = '{1, 1, 1, 0, 1};
  localparam logic [19:0] T_ADDR [NV] = '{20'h00104, 20'hABCDE, 20'hFFFFF, 20'h0, 20'h00000};
  localparam logic [3:0]  T_BE   [NV] = '{4'hF, 4'h3, 4'h8, 4'h0, 4'h5};

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R9 reset busy", {31'b0, busy}, 32'd0);
    chk("R8 reset irq", {31'b0, irq}, 32'd0);
    chk("R12 reset cur_head", 32'(cur_head), 32'd0);

    for (int v = 0; v < NV; v++) begin
      fresh();
      put(0, T_LO[v], T_HI[v]);
      start(0, 64);
      wait_idle();
      chk("R2 R3 table write count", 32'(wcount), 32'(T_N[v]));
      if (T_N[v] == 1) begin
        chk("R2 table addr", 32'(log_addr[0]), 32'(T_ADDR[v]));
        chk("R2 table be", 32'(log_be[0]), 32'(T_BE[v]));
        chk("R2 table data", log_data[0], T_LO[v]);
      end
      chk("R8 completion status", {31'b0, sts_prog}, 32'd1);
      chk("R9 end at tail", 32'(cur_head), 32'd64);
    end

    fresh();
    put(0, 32'd3, 32'h09000123);
    put(2, 32'hA0000001, 32'hA0000002);
    put(4, 32'hA0000003, 32'h0);
    put(6, 32'h000000AA, 32'h01F00055);
    start(0, 64); wait_idle();
    chk("R4 odd count writes", 32'(wcount), 32'd4);
    chk("R4 data1", log_data[0], 32'hA0000001);
    chk("R4 data3", log_data[2], 32'hA0000003);
    chk("R4 addr", 32'(log_addr[2]), 32'h123);
    chk("R4 be", 32'(log_be[1]), 32'hF);
    chk("R4 pad skipped", 32'(log_addr[3]), 32'h55);

    fresh();
    put(0, 32'd2, 32'h09000777);
    put(2, 32'hB1, 32'hB2);
    put(4, 32'h000000CC, 32'h01F00066);
    start(0, 64); wait_idle();
    chk("R4 even count writes", 32'(wcount), 32'd3);
    chk("R4 even next", 32'(log_data[2]), 32'hCC);

    fresh();
    put(0, 32'd0, 32'h09000777);
    put(2, 32'h000000DD, 32'h01F00066);
    start(0, 64); wait_idle();
    chk("R4 zero count", 32'(wcount), 32'd1);
    chk("R4 zero count next", log_data[0], 32'hDD);

    fresh();
    put(0, 32'd5, 32'h02000000);
    put(2, 32'h1, 32'h01F00010);
    start(0, 64);
    for (int k = 0; k < 12 && busy; k++) begin
      step(3); us_tick = 1'b1; us_issued++; step(); us_tick = 1'b0;
    end
    wait_idle();
    chk("R5 ticks before write", 32'(us_at_wr), 32'd5);

    fresh();
    put(0, 32'd0, 32'h02000000);
    put(2, 32'h1, 32'h01F00010);
    start(0, 64); wait_idle();
    chk("R5 zero wait", 32'(wcount), 32'd1);
    chk("R5 zero wait ticks", 32'(us_at_wr), 32'd0);

    fresh();
    put(0, 32'd2, 32'h04000000);
    put(2, 32'h1, 32'h01F00010);
    start(0, 64);
    for (int k = 0; k < 12 && busy; k++) begin
      step(2); us_tick = 1'b1; us_issued++; step(); us_tick = 1'b0;
      if (k % 2 == 1) begin step(); pulse_vb(); end
    end
    wait_idle();
    chk("R6 vblanks before write", 32'(vb_at_wr), 32'd2);

    fresh();
    put(0, 32'h00300010, 32'h05000012);
    put(2, 32'h1, 32'h01F00321);
    start(0, 64); step(5);
    chk("R7 start pulses", 32'(slcount), 32'd1);
    chk("R7 op", 32'(cap_op), 32'h05);
    chk("R7 lo", cap_lo, 32'h00300010);
    chk("R7 hi", 32'(cap_hi), 32'h12);
    chk("R7 still waiting", {31'b0, busy}, 32'd1);
    chk("R7 no write yet", 32'(wcount), 32'd0);
    sl_done = 1'b1; step(); sl_done = 1'b0;
    wait_idle();
    chk("R7 resumes", 32'(wcount), 32'd1);

    fresh();
    put(0, 32'd0, 32'h07000000);
    put(2, 32'd1, 32'h04000000);
    start(0, 64); step(4);
    chk("R8 irq instr busy", {31'b0, busy}, 32'd1);
    chk("R8 irq instr status", {31'b0, sts_prog}, 32'd1);
    chk("R8 irq out", {31'b0, irq}, 32'd1);
    clr_prog = 1'b1; step(); clr_prog = 1'b0;
    chk("R8 cleared", {31'b0, sts_prog}, 32'd0);
    pulse_vb(); wait_idle();
    chk("R8 set on completion", {31'b0, sts_prog}, 32'd1);

    fresh();
    start(0, 32'h20); step();
    chk("R10 not started", {31'b0, busy}, 32'd0);
    chk("R10 align err", {31'b0, sts_align_err}, 32'd1);
    chk("R10 irq", {31'b0, irq}, 32'd1);
    clr_err = 1'b1; step(); clr_err = 1'b0;
    chk("R10 cleared", {31'b0, sts_align_err}, 32'd0);

    fresh();
    put(0, 32'd1, 32'h04000000);
    put(16, 32'h99, 32'h01F00777);
    start(0, 64); step(3);
    start(0, 128); step(2);
    pulse_vb(); wait_idle();
    chk("R11 tail ignored writes", 32'(wcount), 32'd0);
    chk("R11 stopped at old tail", 32'(cur_head), 32'd64);

    fresh();
    put(4, 32'd10, 32'h02000000);
    put(6, 32'h1, 32'h01F00010);
    start(0, 64); step(6);
    halt = 1'b1; step(); halt = 1'b0;
    chk("R12 halted idle", {31'b0, busy}, 32'd0);
    chk("R12 head kept", 32'(cur_head), 32'd16);
    step(20);
    chk("R12 no writes", 32'(wcount), 32'd0);
    chk("R12 no completion", {31'b0, sts_prog}, 32'd0);

    fresh();
    put(0, 32'h11, 32'h01F00001);
    put(2, 32'h0, 32'h0A000000);
    put(4, 32'h22, 32'h01F00002);
    start(0, 64); wait_idle();
    chk("R13 op err", {31'b0, sts_op_err}, 32'd1);
    chk("R13 head at bad op", 32'(cur_head), 32'd8);
    chk("R13 nothing after", 32'(wcount), 32'd1);
    chk("R13 no completion", {31'b0, sts_prog}, 32'd0);

    fresh();
    put(16, 32'h5A5A5A5A, 32'h01F00444);
    start(8, 128); wait_idle();
    chk("R1 head slot writes", 32'(wcount), 32'd1);
    chk("R1 head slot data", log_data[0], 32'h5A5A5A5A);

    fresh();
    start(8, 64); wait_idle();
    chk("R9 head equals tail", {31'b0, sts_prog}, 32'd1);
    chk("R9 head equals tail no writes", 32'(wcount), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule